// File: doc/BRIEF.md
# Stack Push/Pull Instruction Sequencer

This block runs the bus cycles for the four one-byte stack instructions of an 8-bit accumulator processor. These are push accumulator, push status, pull accumulator and pull status. When the surrounding core has decoded an opcode, it pulses `start` together with that opcode while the current program counter sits on `pcIn`. The sequencer then drives the memory address, the write data and the read/write strobe for each cycle of the instruction. It owns the stack pointer, the accumulator and the status flags, and updates them itself. On the cycle that issues the next opcode fetch it raises `done`. The owner of the program counter then advances it by one.

The stack is a single 256-byte page selected by a parameter. The stack pointer wraps within that page in both directions. Other units of the core, such as the ALU and the flag instructions, write the accumulator and the flags through two load ports. `flagsOut` shows the status byte laid out as bit 7 N, bit 6 V, bit 5 always 1, bit 4 B, bit 3 D, bit 2 I, bit 1 Z and bit 0 C. The flag load port uses the same layout, and its bit 5 is ignored.

Top module: `stk_seq`

## Requirements
- R1: After a synchronous active-high reset, `spOut` equals SP_RESET (0xFD by default), `accOut` is 0x00, `flagsOut` is FLAGS_RESET with bit 5 forced to 1 (0x24 by default), `done` is low and `memRead` is high.
- R2: The sequencer is idle when no instruction is running. `start` is accepted only while it is idle, and only with one of four opcodes: 0x48 push accumulator, 0x08 push status, 0x68 pull accumulator, 0x28 pull status. Any other opcode, or a `start` during a running instruction, has no effect on the bus, the registers or `done`.
- R3: A push lasts three cycles, counted from the cycle after `start` is sampled. Cycle 0 reads `pcIn`. Cycle 1 writes to address {STACK_PAGE, SP}. Cycle 2 reads `pcIn`+1.
- R4: After the stack write of a push, SP decreases by one and wraps from 0x00 to 0xFF.
- R5: A pull lasts four cycles. Cycle 0 reads `pcIn`. Cycle 1 reads {STACK_PAGE, SP}. Cycle 2 reads {STACK_PAGE, SP+1}. Cycle 3 reads `pcIn`+1, and the pulled value is the `memRdata` seen in cycle 3.
- R6: After cycle 1 of a pull, SP increases by one and wraps from 0xFF to 0x00.
- R7: Push accumulator writes `accOut`. Pull accumulator loads the pulled byte into the accumulator, copies its bit 7 into N, and sets Z when the byte is zero (clearing it otherwise).
- R8: Push status writes the byte {N, V, 1, 1, D, I, Z, C} from bit 7 down to bit 0, so the break bit is always stored as 1. For example, with only D and Z set the byte is 0x3A.
- R9: Pull status takes N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of the pulled byte. The live B flag and bit 5 keep their values.
- R10: `memRead` is low for exactly one cycle per push, in cycle 1 and at a stack-page address. It is high on every other cycle.
- R11: `done` is a one-cycle pulse on the fetch cycle, and `memAddr` equals `pcIn`+1 on that cycle.
- R12: Pushes leave the accumulator and the flags unchanged.
- R13: A load strobe on `extAccWe` or `extFlagsWe` updates the accumulator or the flags on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the decoded instruction in `opcode` |
| opcode | input | 8 | Decoded opcode |
| pcIn | input | PC_W | Address of the current instruction |
| memRdata | input | 8 | Read data, valid the cycle after the read |
| extAccWe | input | 1 | Accumulator load strobe from other units |
| extAccIn | input | 8 | Accumulator load value |
| extFlagsWe | input | 1 | Flags load strobe from other units |
| extFlagsIn | input | 8 | Flags load value (bit 5 ignored) |
| memAddr | output | PC_W | Memory address |
| memWdata | output | 8 | Write data, meaningful when `memRead` is low |
| memRead | output | 1 | 1 = read, 0 = write |
| done | output | 1 | Next opcode fetch is being issued |
| spOut | output | 8 | Stack pointer |
| accOut | output | 8 | Accumulator |
| flagsOut | output | 8 | Status byte, bit 5 fixed at 1 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, stack page 0x01 and a reset stack pointer of 0xFD. These values reproduce the known example bytes, 0x89 stored at 0x01FD and the status byte 0x3A. From 0xFD, 253 pushes reach a stack pointer of 0x00, so the bench can run both the downward wrap and the upward wrap within a short run. A behavioural model checks the address, strobe, write data and `done` on every cycle of every instruction. It also checks the registers after each instruction.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  localparam logic [7:0] OP_PUSH_P = 8'h08;
  localparam logic [7:0] OP_PULL_P = 8'h28;
  localparam logic [7:0] OP_PUSH_A = 8'h48;
  localparam logic [7:0] OP_PULL_A = 8'h68;

  // bit 1: pull, bit 0: status register involved
  typedef enum logic [1:0] {
    KIND_PUSH_A = 2'b00,
    KIND_PUSH_P = 2'b01,
    KIND_PULL_A = 2'b10,
    KIND_PULL_P = 2'b11
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic stackAddr;  // address = stack page | SP
    logic fetchAddr;  // address = PC + 1
    logic wrEn;       // drive a write this cycle
    logic spDec;
    logic spInc;
    logic selFlags;   // write data from packed status
    logic loadAcc;    // take bus byte into A
    logic loadFlags;  // take bus byte into flags
  } seqStrobes_t;

  // Status byte bit positions
  localparam int FL_N = 7;
  localparam int FL_V = 6;
  localparam int FL_U = 5;
  localparam int FL_B = 4;

  function automatic logic [7:0] packStatus(input logic [7:0] fl);
    packStatus = {fl[FL_N], fl[FL_V], 1'b1, 1'b1, fl[3:0]};
  endfunction

  function automatic logic [7:0] unpackStatus(input logic [7:0] cur, input logic [7:0] pulled);
    unpackStatus = {pulled[FL_N], pulled[FL_V], 1'b1, cur[FL_B], pulled[3:0]};
  endfunction

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  opcode,
  output seqStrobes_t strb,
  output logic        done
);

  localparam int CYC_W = 2;
  localparam logic [CYC_W-1:0] LAST_PUSH = CYC_W'(2);
  localparam logic [CYC_W-1:0] LAST_PULL = CYC_W'(3);

  logic             busy;
  logic [CYC_W-1:0] cyc;
  opKind_t          kind;
  logic             opValid;
  opKind_t          opKind;
  logic             isPull;
  logic             isFlags;

  always_comb begin
    opValid = 1'b1;
    opKind  = KIND_PUSH_A;
    case (opcode)
      OP_PUSH_A: opKind = KIND_PUSH_A;
      OP_PUSH_P: opKind = KIND_PUSH_P;
      OP_PULL_A: opKind = KIND_PULL_A;
      OP_PULL_P: opKind = KIND_PULL_P;
      default:   opValid = 1'b0;
    endcase
  end

  assign isPull  = kind[1];
  assign isFlags = kind[0];
  assign done    = busy && (cyc == (isPull ? LAST_PULL : LAST_PUSH));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cyc  <= '0;
      kind <= KIND_PUSH_A;
    end else if (!busy) begin
      if (start && opValid) begin
        busy <= 1'b1;
        cyc  <= '0;
        kind <= opKind;
      end
    end else if (done) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.selFlags = isFlags;
    if (busy) begin
      case (cyc)
        2'd1: begin
          strb.stackAddr = 1'b1;
          if (isPull) strb.spInc = 1'b1;
          else begin
            strb.wrEn  = 1'b1;
            strb.spDec = 1'b1;
          end
        end
        2'd2: begin
          if (isPull) strb.stackAddr = 1'b1;
          else        strb.fetchAddr = 1'b1;
        end
        2'd3: begin
          strb.fetchAddr = 1'b1;
          strb.loadAcc   = !isFlags;
          strb.loadFlags = isFlags;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stk_seq_dpath.sv
module stk_seq_dpath
  import stk_seq_pkg::*;
#(
  parameter int              PC_W        = 16,
  parameter logic [PC_W-9:0] STACK_PAGE  = 'h01,
  parameter logic [7:0]      SP_RESET    = 8'hFD,
  parameter logic [7:0]      FLAGS_RESET = 8'h24
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobes_t     strb,
  input  logic [PC_W-1:0] pcIn,
  input  logic [7:0]      memRdata,
  input  logic            extAccWe,
  input  logic [7:0]      extAccIn,
  input  logic            extFlagsWe,
  input  logic [7:0]      extFlagsIn,
  output logic [PC_W-1:0] memAddr,
  output logic [7:0]      memWdata,
  output logic            memRead,
  output logic [7:0]      spOut,
  output logic [7:0]      accOut,
  output logic [7:0]      flagsOut
);

  localparam logic [7:0] BIT5 = 8'h20;

  logic [7:0] sp;
  logic [7:0] acc;
  logic [7:0] flags;
  logic [7:0] flagsNext;

  always_ff @(posedge clk) begin
    if (rst) sp <= SP_RESET;
    else if (strb.spDec) sp <= sp - 8'd1;
    else if (strb.spInc) sp <= sp + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= 8'h00;
    else if (strb.loadAcc) acc <= memRdata;
    else if (extAccWe) acc <= extAccIn;
  end

  always_comb begin
    flagsNext = flags;
    if (strb.loadFlags) begin
      flagsNext = unpackStatus(flags, memRdata);
    end else if (strb.loadAcc) begin
      flagsNext[FL_N] = memRdata[7];
      flagsNext[1]    = (memRdata == 8'h00);
    end else if (extFlagsWe) begin
      flagsNext = extFlagsIn | BIT5;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= FLAGS_RESET | BIT5;
    else     flags <= flagsNext;
  end

  always_comb begin
    if (strb.stackAddr)      memAddr = {STACK_PAGE, sp};
    else if (strb.fetchAddr) memAddr = pcIn + PC_W'(1);
    else                     memAddr = pcIn;
  end

  assign memWdata = strb.selFlags ? packStatus(flags) : acc;
  assign memRead  = !strb.wrEn;
  assign spOut    = sp;
  assign accOut   = acc;
  assign flagsOut = flags;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter int              PC_W        = 16,
  parameter logic [PC_W-9:0] STACK_PAGE  = 'h01,
  parameter logic [7:0]      SP_RESET    = 8'hFD,
  parameter logic [7:0]      FLAGS_RESET = 8'h24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [PC_W-1:0] pcIn,
  input  logic [7:0]      memRdata,
  input  logic            extAccWe,
  input  logic [7:0]      extAccIn,
  input  logic            extFlagsWe,
  input  logic [7:0]      extFlagsIn,
  output logic [PC_W-1:0] memAddr,
  output logic [7:0]      memWdata,
  output logic            memRead,
  output logic            done,
  output logic [7:0]      spOut,
  output logic [7:0]      accOut,
  output logic [7:0]      flagsOut
);

  seqStrobes_t strb;

  stk_seq_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (opcode),
    .strb   (strb),
    .done   (done)
  );

  stk_seq_dpath #(
    .PC_W        (PC_W),
    .STACK_PAGE  (STACK_PAGE),
    .SP_RESET    (SP_RESET),
    .FLAGS_RESET (FLAGS_RESET)
  ) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .pcIn       (pcIn),
    .memRdata   (memRdata),
    .extAccWe   (extAccWe),
    .extAccIn   (extAccIn),
    .extFlagsWe (extFlagsWe),
    .extFlagsIn (extFlagsIn),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRead    (memRead),
    .spOut      (spOut),
    .accOut     (accOut),
    .flagsOut   (flagsOut)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-9:0] STACK_PAGE = 'h01
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pcIn,
  input logic [PC_W-1:0] memAddr,
  input logic            memRead,
  input logic            done,
  input logic [7:0]      spOut
);

  // R10: writes only go to the stack page
  a_r10_write_in_page: assert property (@(posedge clk) disable iff (rst)
    !memRead |-> memAddr[PC_W-1:8] == STACK_PAGE);

  // R10: a write lasts one cycle
  a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
    !memRead |=> memRead);

  // R4: stack pointer steps down after the write, with wrap
  a_r4_sp_dec: assert property (@(posedge clk) disable iff (rst)
    !memRead |=> spOut == $past(spOut) - 8'd1);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: the fetch goes to the following byte
  a_r11_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    done |-> memAddr == pcIn + PC_W'(1));

endmodule

bind stk_seq stk_seq_chk #(
  .PC_W       (PC_W),
  .STACK_PAGE (STACK_PAGE)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pcIn    (pcIn),
  .memAddr (memAddr),
  .memRead (memRead),
  .done    (done),
  .spOut   (spOut)
);

// File: tb/stk_seq_tb_top.sv
`timescale 1ns/1ps
module stk_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pcIn = 16'h8000;
  logic [7:0]  memRdata = 8'h00;
  logic        extAccWe = 1'b0;
  logic [7:0]  extAccIn = 8'h00;
  logic        extFlagsWe = 1'b0;
  logic [7:0]  extFlagsIn = 8'h00;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memRead;
  logic        done;
  logic [7:0]  spOut;
  logic [7:0]  accOut;
  logic [7:0]  flagsOut;

  always #2.5 clk = ~clk;

  stk_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pcIn(pcIn),
    .memRdata(memRdata), .extAccWe(extAccWe), .extAccIn(extAccIn),
    .extFlagsWe(extFlagsWe), .extFlagsIn(extFlagsIn), .memAddr(memAddr),
    .memWdata(memWdata), .memRead(memRead), .done(done), .spOut(spOut),
    .accOut(accOut), .flagsOut(flagsOut)
  );

  // Environment memory: stack page holds data, elsewhere returns 0xEA
  logic [7:0] stkMem [0:255];
  always @(posedge clk) begin
    if (memRead) memRdata <= (memAddr[15:8] == 8'h01) ? stkMem[memAddr[7:0]] : 8'hEA;
    else if (memAddr[15:8] == 8'h01) stkMem[memAddr[7:0]] <= memWdata;
  end

  // Reference model state
  int          nChecks = 0;
  int          nErrs = 0;
  logic [7:0]  mSp, mAcc, mFlags;
  logic [7:0]  mStk [0:255];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    chk(req, "sp", spOut, mSp);
    chk(req, "acc", accOut, mAcc);
    chk(req, "flags", flagsOut, mFlags);
  endtask

  task automatic setAcc(input logic [7:0] v);
    @(negedge clk); extAccWe = 1'b1; extAccIn = v;
    @(posedge clk); #1 extAccWe = 1'b0; mAcc = v;
    @(negedge clk); chk("R13", "acc load", accOut, v);
  endtask

  task automatic setFlags(input logic [7:0] v);
    @(negedge clk); extFlagsWe = 1'b1; extFlagsIn = v;
    @(posedge clk); #1 extFlagsWe = 1'b0; mFlags = v | 8'h20;
    @(negedge clk); chk("R13", "flags load", flagsOut, v | 8'h20);
  endtask

  // Runs one instruction and compares every cycle; glitch pulses start mid-instruction
  task automatic runOp(input logic [7:0] op, input bit glitch);
    bit isPull = (op == 8'h68) || (op == 8'h28);
    bit isP = (op == 8'h08) || (op == 8'h28);
    int len = isPull ? 4 : 3;
    logic [7:0] pushByte;
    logic [7:0] v;
    @(negedge clk); start = 1'b1; opcode = op;
    @(posedge clk); #1 start = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R3", "c0 addr", memAddr, pcIn);
        chk("R3", "c0 read", memRead, 1);
      end else if (k == len - 1) begin
        chk("R11", "fetch addr", memAddr, pcIn + 16'd1);
        chk("R11", "done", done, 1);
        chk("R10", "fetch read", memRead, 1);
      end else if (isPull) begin
        chk("R5", "stack addr", memAddr, {8'h01, mSp});
        chk("R10", "pull read", memRead, 1);
      end else begin
        pushByte = isP ? {mFlags[7:6], 2'b11, mFlags[3:0]} : mAcc;
        chk("R3", "push addr", memAddr, {8'h01, mSp});
        chk("R10", "push write", memRead, 0);
        chk(isP ? "R8" : "R7", "push data", memWdata, pushByte);
      end
      if (k != len - 1) chk("R11", "no early done", done, 0);
      if (glitch && k == 1) begin
        start = 1'b1; opcode = 8'h48;
      end
      @(posedge clk);
      #1 start = 1'b0;
      if (!isPull && k == 1) begin
        mStk[mSp] = pushByte;
        mSp = mSp - 8'd1;
      end
      if (isPull && k == 1) mSp = mSp + 8'd1;
      if (isPull && k == 3) begin
        v = mStk[mSp];
        if (isP) mFlags = {v[7:6], 1'b1, mFlags[4], v[3:0]};
        else begin
          mAcc = v; mFlags[7] = v[7]; mFlags[1] = (v == 8'h00);
        end
      end
    end
    @(negedge clk);
    chkRegs(isPull ? (isP ? "R9" : "R7") : "R12");
    chk("R11", "done low after", done, 0);
    pcIn = pcIn + 16'd1;
  endtask

  task automatic idleCheck(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle done", done, 0);
      chk(req, "idle addr", memAddr, pcIn);
      chk(req, "idle read", memRead, 1);
    end
    chkRegs(req);
  endtask

  initial begin
    #1000000;
    nErrs++; nChecks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin stkMem[i] = 8'h00; mStk[i] = 8'h00; end
    mSp = 8'hFD; mAcc = 8'h00; mFlags = 8'h24;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chkRegs("R1");
    chk("R1", "done", done, 0);
    chk("R1", "read", memRead, 1);

    // R7 push A then pull A with N set
    setAcc(8'h89);
    runOp(8'h48, 1'b0);
    chk("R4", "sp after push", spOut, 8'hFC);
    setAcc(8'h00);
    runOp(8'h68, 1'b0);
    chk("R7", "pulled A", accOut, 8'h89);
    chk("R6", "sp after pull", spOut, 8'hFD);

    // R8 status packing: D and Z set, B clear -> 0x3A
    setFlags(8'h0A);
    runOp(8'h08, 1'b0);
    chk("R8", "stored status", stkMem[8'hFD], 8'h3A);
    setFlags(8'h85);
    runOp(8'h28, 1'b0);
    chk("R9", "restored flags", flagsOut, 8'h2A);

    // R9 B kept at 1, bit 5 of byte ignored
    setAcc(8'hC5);
    runOp(8'h48, 1'b0);
    setFlags(8'h10);
    runOp(8'h28, 1'b0);
    chk("R9", "flags keep B", flagsOut, 8'hF5);

    // R7 pull of zero sets Z
    setAcc(8'h00);
    runOp(8'h48, 1'b0);
    setAcc(8'h55);
    runOp(8'h68, 1'b0);
    chk("R7", "zero flag", flagsOut[1], 1);
    chk("R7", "neg flag", flagsOut[7], 0);

    // R2 unsupported opcode ignored
    @(negedge clk); start = 1'b1; opcode = 8'hEA;
    @(posedge clk); #1 start = 1'b0;
    idleCheck("R2", 4);

    // R2 start during a running instruction ignored
    setAcc(8'h3C);
    runOp(8'h48, 1'b1);
    idleCheck("R2", 3);
    runOp(8'h68, 1'b1);
    idleCheck("R2", 3);

    // R4 / R6 wrap at page edges
    setAcc(8'h5A);
    while (mSp != 8'h00) runOp(8'h48, 1'b0);
    setAcc(8'h77);
    runOp(8'h48, 1'b0);
    chk("R4", "sp wrap down", spOut, 8'hFF);
    setAcc(8'h00);
    runOp(8'h68, 1'b0);
    chk("R6", "sp wrap up", spOut, 8'h00);
    chk("R5", "pulled from 0x0100", accOut, 8'h77);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule